// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the multi-cycle control unit that starts interrupt service and carries out the return-from-interrupt operation in a small 16-bit processor with two privilege levels. It owns the program counter, the processor status word and the architectural stack pointer (R6). It also owns two shadow registers that hold the top of the supervisor stack and the top of the user stack. When the privilege level changes, it exchanges R6 with the matching shadow register.

On entry it switches to the supervisor stack if the machine was in user mode. It then pushes the status word and the PC through a word-wide memory port with a ready handshake. It raises the running priority, enters supervisor mode and jumps to the supplied service-routine address.

On return it first checks privilege. It pops the PC and then the status word. It goes back to the user stack only when the restored status word marks user mode. Vector lookup, instruction decode and the datapath sit outside this block. They supply only a request with its priority, a routine address and a return strobe.

Top module: `irq_rti_seq`

## Requirements
- R1: After reset, pc equals PC_INIT (0x0200), psr equals 0x8000 (user mode, priority 0), r6 equals USP_INIT (0xFE00), the supervisor shadow holds SSP_INIT (0x3000), and busy and priv_fault are 0.
- R2: An interrupt request is accepted only when irq_pri is strictly greater than the running priority in psr bits 10:8. A request of equal or lower priority leaves pc, psr and r6 unchanged. The privilege bit psr[15] plays no part in acceptance.
- R3: When a request is accepted in user mode (psr[15]=1), the current r6 is saved in the user shadow register, and the supervisor shadow value becomes the new stack pointer before anything is pushed.
- R4: The stack grows downward, and each push first decrements r6 and then writes at r6. The old status word is written at SP-1, then the old PC at SP-2, so r6 ends at SP-2.
- R5: When entry completes, psr[15] is 0, psr[10:8] holds the accepted irq_pri, the other psr bits are kept, and pc holds the irq_addr that was latched at acceptance.
- R6: When a request is accepted in supervisor mode (psr[15]=0), no stack swap takes place. The frame is pushed below the current r6, and the shadow registers stay unchanged.
- R7: A return strobe in user mode does nothing to pc, psr, r6 or memory. Instead, priv_fault is high for exactly one cycle.
- R8: A legal return reads the PC from r6 and then the status word from r6+1. It loads both, and r6 ends at its starting value plus 2.
- R9: If the restored psr[15] is 1, the incremented r6 is saved in the supervisor shadow register, and r6 is loaded from the user shadow register.
- R10: busy is high from the cycle after acceptance until the final PC load. Requests and return strobes that arrive while busy is high are ignored.
- R11: When an interrupt request and a return strobe arrive in the same idle cycle, an accepted interrupt wins and the strobe is dropped. If the interrupt is not accepted, the return proceeds.
- R12: Once mem_req is raised, mem_req, mem_we, mem_addr and mem_wdata stay stable until a cycle with mem_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Interrupt request |
| irq_pri | input | 3 | Priority of the request |
| irq_addr | input | 16 | Service-routine start address |
| rti_req | input | 1 | Return-from-interrupt strobe |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid when mem_ready is high |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Sequence in progress |
| priv_fault | output | 1 | One-cycle pulse on a return attempted in user mode |
| pc | output | 16 | Program counter |
| psr | output | 16 | Status word |
| r6 | output | 16 | Architectural stack pointer |

## Verification
An interrupt request and a return strobe can land in the same idle cycle. The bench provokes this twice in one vector walk.

The first time, the request outranks the running priority. The final pc, psr and r6 must then show a completed entry and no trace of a return.

The second time, the request is only equal to the running priority, so it must be dropped while the return runs to completion back into user mode. A third collision is raised while a sequence is already busy, and it must leave the entry in progress undisturbed.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    localparam int DW    = 16;
    localparam int PRI_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_PSR,
        ST_PUSH_PC,
        ST_POP_PC,
        ST_POP_PSR
    } seq_state_t;

    typedef struct packed {
        seq_state_t       state;
        logic [DW-1:0]    pc;
        logic [DW-1:0]    psr;
        logic [DW-1:0]    r6;
        logic [DW-1:0]    ssp;
        logic [DW-1:0]    usp;
        logic [DW-1:0]    vec;
        logic [PRI_W-1:0] pri;
        logic             fault;
    } seq_regs_t;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
    parameter int PRI_W = 3
) (
    input  logic             idle,
    input  logic             req,
    input  logic [PRI_W-1:0] req_pri,
    input  logic [PRI_W-1:0] run_pri,
    output logic             accept
);
    // strictly higher priority only; privilege does not take part
    always_comb begin
        accept = idle && req && (req_pri > run_pri);
    end
endmodule

// File: rtl/stk_step.sv
module stk_step #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] sp,
    output logic [DW-1:0] sp_dec,
    output logic [DW-1:0] sp_inc
);
    localparam logic [DW-1:0] ONE = DW'(1);
    always_comb begin
        sp_dec = sp - ONE;
        sp_inc = sp + ONE;
    end
endmodule

// File: rtl/irq_rti_seq.sv
module irq_rti_seq
    import irq_seq_pkg::*;
#(
    parameter logic [DW-1:0] PC_INIT  = 16'h0200,
    parameter logic [DW-1:0] PSR_INIT = 16'h8000,
    parameter logic [DW-1:0] SSP_INIT = 16'h3000,
    parameter logic [DW-1:0] USP_INIT = 16'hFE00,
    parameter int            PRIV_BIT = 15,
    parameter int            PRI_LSB  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [PRI_W-1:0] irq_pri,
    input  logic [DW-1:0]    irq_addr,
    input  logic             rti_req,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             mem_ready,
    output logic             busy,
    output logic             priv_fault,
    output logic [DW-1:0]    pc,
    output logic [DW-1:0]    psr,
    output logic [DW-1:0]    r6
);
    seq_regs_t q, d;

    logic          idle;
    logic          accept;
    logic          user_mode;
    logic [DW-1:0] r6_dec, r6_inc, ssp_dec, ssp_unused;

    assign idle      = (q.state == ST_IDLE);
    assign user_mode = q.psr[PRIV_BIT];

    irq_gate #(.PRI_W(PRI_W)) u_gate (
        .idle    (idle),
        .req     (irq_req),
        .req_pri (irq_pri),
        .run_pri (q.psr[PRI_LSB +: PRI_W]),
        .accept  (accept)
    );

    stk_step #(.DW(DW)) u_r6_step (
        .sp     (q.r6),
        .sp_dec (r6_dec),
        .sp_inc (r6_inc)
    );

    stk_step #(.DW(DW)) u_ssp_step (
        .sp     (q.ssp),
        .sp_dec (ssp_dec),
        .sp_inc (ssp_unused)
    );

    // memory port driven from the state alone
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.r6;
        mem_wdata = '0;
        case (q.state)
            ST_PUSH_PSR: begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = q.psr; end
            ST_PUSH_PC:  begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = q.pc;  end
            ST_POP_PC,
            ST_POP_PSR:  begin mem_req = 1'b1; end
            default: ;
        endcase
    end

    always_comb begin
        d       = q;
        d.fault = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (accept) begin
                    d.vec   = irq_addr;
                    d.pri   = irq_pri;
                    d.state = ST_PUSH_PSR;
                    if (user_mode) begin
                        d.usp = q.r6;
                        d.r6  = ssp_dec;
                    end else begin
                        d.r6  = r6_dec;
                    end
                end else if (rti_req) begin
                    if (user_mode) d.fault = 1'b1;
                    else           d.state = ST_POP_PC;
                end
            end
            ST_PUSH_PSR: begin
                if (mem_ready) begin
                    d.r6    = r6_dec;
                    d.state = ST_PUSH_PC;
                end
            end
            ST_PUSH_PC: begin
                if (mem_ready) begin
                    d.psr[PRIV_BIT]           = 1'b0;
                    d.psr[PRI_LSB +: PRI_W]   = q.pri;
                    d.pc                      = q.vec;
                    d.state                   = ST_IDLE;
                end
            end
            ST_POP_PC: begin
                if (mem_ready) begin
                    d.pc    = mem_rdata;
                    d.r6    = r6_inc;
                    d.state = ST_POP_PSR;
                end
            end
            ST_POP_PSR: begin
                if (mem_ready) begin
                    d.psr   = mem_rdata;
                    d.state = ST_IDLE;
                    if (mem_rdata[PRIV_BIT]) begin
                        d.ssp = r6_inc;
                        d.r6  = q.usp;
                    end else begin
                        d.r6  = r6_inc;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.pc    <= PC_INIT;
            q.psr   <= PSR_INIT;
            q.r6    <= USP_INIT;
            q.ssp   <= SSP_INIT;
            q.usp   <= USP_INIT;
            q.vec   <= '0;
            q.pri   <= '0;
            q.fault <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign busy       = !idle;
    assign priv_fault = q.fault;
    assign pc         = q.pc;
    assign psr        = q.psr;
    assign r6         = q.r6;

    // R12: an access waiting for ready keeps every request field
    p_mem_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we)
                                     && $stable(mem_addr) && $stable(mem_wdata)));

    // R10: memory traffic only while a sequence is running
    p_mem_in_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7: the fault pulse leaves user mode in place and lasts one cycle
    p_fault_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        priv_fault |-> (psr[PRIV_BIT] && !busy) ##1 !priv_fault);

    // R5: the final push hands over supervisor mode, priority and routine address
    p_entry_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_PUSH_PC && mem_ready) |=>
            (!psr[PRIV_BIT] && pc == $past(q.vec)
             && psr[PRI_LSB +: PRI_W] == $past(q.pri) && !busy));

    // R4: writes happen only during the push steps
    p_write_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (q.state == ST_PUSH_PSR || q.state == ST_PUSH_PC));

    // R9: returning to user mode leaves r6 at the user shadow value
    p_user_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_POP_PSR && mem_ready && mem_rdata[PRIV_BIT]) |=>
            (r6 == $past(q.usp)));
endmodule

// File: tb/tb_irq_rti_seq.sv
module tb_irq_rti_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [2:0]  irq_pri = '0;
    logic [15:0] irq_addr = '0;
    logic        rti_req = 1'b0;
    logic        mem_req, mem_we, mem_ready, busy, priv_fault;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, pc, psr, r6;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_rti_seq dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_pri(irq_pri),
        .irq_addr(irq_addr), .rti_req(rti_req), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy),
        .priv_fault(priv_fault), .pc(pc), .psr(psr), .r6(r6)
    );

    logic [15:0] mem [0:255];
    logic [7:0]  lfsr = 8'hA5;
    assign mem_ready = mem_req && lfsr[0];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (mem_req && mem_we && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    end

    logic fault_seen = 1'b0;
    always @(negedge clk) if (priv_fault) fault_seen <= 1'b1;

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 400 && busy; n++) @(negedge clk);
        if (busy) chk("R10 busy stuck", 16'(busy), 16'h0);
        @(negedge clk);
    endtask

    // op: 1 irq, 2 rti, 3 both | pri | vec | pc | psr | r6 | fault
    localparam int NV = 10;
    localparam logic [69:0] TBL [0:NV-1] = '{
        {2'd1, 3'd3, 16'h1100, 16'h1100, 16'h0300, 16'h2FFE, 1'b0}, // R3 R4 R5
        {2'd1, 3'd3, 16'h1200, 16'h1100, 16'h0300, 16'h2FFE, 1'b0}, // R2 equal
        {2'd1, 3'd5, 16'h1500, 16'h1500, 16'h0500, 16'h2FFC, 1'b0}, // R6 nested
        {2'd2, 3'd0, 16'h0000, 16'h1100, 16'h0300, 16'h2FFE, 1'b0}, // R8
        {2'd2, 3'd0, 16'h0000, 16'h0200, 16'h8000, 16'hFE00, 1'b0}, // R9
        {2'd2, 3'd0, 16'h0000, 16'h0200, 16'h8000, 16'hFE00, 1'b1}, // R7
        {2'd1, 3'd0, 16'h1300, 16'h0200, 16'h8000, 16'hFE00, 1'b0}, // R2 user
        {2'd3, 3'd1, 16'h1800, 16'h1800, 16'h0100, 16'h2FFE, 1'b0}, // R11 irq wins
        {2'd3, 3'd1, 16'h1900, 16'h0200, 16'h8000, 16'hFE00, 1'b0}, // R11 rti runs
        {2'd1, 3'd7, 16'h1700, 16'h1700, 16'h0700, 16'h2FFE, 1'b0}  // R3 ssp kept
    };

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pc", pc, 16'h0200);
        chk("R1 psr", psr, 16'h8000);
        chk("R1 r6", r6, 16'hFE00);
        chk("R1 busy", 16'(busy), 16'h0);
        chk("R1 fault", 16'(priv_fault), 16'h0);

        for (int i = 0; i < NV; i++) begin
            logic [69:0] v;
            v = TBL[i];
            fault_seen = 1'b0;
            irq_req  = v[68];
            rti_req  = v[69];
            irq_pri  = v[67:65];
            irq_addr = v[64:49];
            @(negedge clk);
            irq_req = 1'b0; rti_req = 1'b0;
            wait_idle();
            chk($sformatf("R2/R5/R8 pc vec%0d", i), pc, v[48:33]);
            chk($sformatf("R5/R9 psr vec%0d", i), psr, v[32:17]);
            chk($sformatf("R3/R4/R9 r6 vec%0d", i), r6, v[16:1]);
            chk($sformatf("R7 fault vec%0d", i), 16'(fault_seen), 16'(v[0]));
            if (i == 0) begin
                chk("R4 psr slot", mem[8'hFF], 16'h8000);
                chk("R4 pc slot", mem[8'hFE], 16'h0200);
            end
            if (i == 2) begin
                chk("R6 nested psr slot", mem[8'hFD], 16'h0300);
                chk("R6 nested pc slot", mem[8'hFC], 16'h1100);
            end
        end

        // return to user mode again: R8 R9
        rti_req = 1'b1; @(negedge clk); rti_req = 1'b0;
        wait_idle();
        chk("R9 r6 back to user", r6, 16'hFE00);
        chk("R8 pc restored", pc, 16'h0200);

        // R10: requests while busy are ignored
        irq_req = 1'b1; irq_pri = 3'd2; irq_addr = 16'h1A00;
        @(negedge clk);
        chk("R10 busy after accept", 16'(busy), 16'h1);
        irq_pri = 3'd6; irq_addr = 16'h1B00; rti_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0; rti_req = 1'b0;
        wait_idle();
        chk("R10 pc", pc, 16'h1A00);
        chk("R10 psr", psr, 16'h0200);
        chk("R10 r6", r6, 16'h2FFE);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule